// File: doc/BRIEF.md
# Integrate-and-Dump Lock Detector

This block decides whether a tracking loop has locked. It counts error samples into windows of a programmable length. During each window it sums the magnitude of every phase error into an 18-bit accumulator. The accumulator starts the window at a preload set below full scale by the wanted threshold. If the sum carries out of the accumulator before the window closes, the window reports lock. A second 18-bit accumulator races the same window during a verify phase. It is fed either with the frequency error magnitude or with a one-bit false-lock indicator, and an overflow there reports false lock.

After an acquisition step in stepped acquisition, a dwell count of windows can be skipped so that the loop settles before lock is judged. In track mode the dwell is always zero. The acquisition sequencer that drives the mode, verify and step inputs and reacts to the flags sits outside this block.

Top module: `lock_detector`

## Requirements
- R1: While reset is low and in the first cycle after it, `lock_o`, `false_lock_o` and `done_o` are 0.
- R2: A window holds exactly P+2 valid samples, where P is the 10-bit integration preload. Cycles with `smp_vld` low are not counted. `done_o` pulses high for one cycle in the cycle after the last sample of the window, and never in two adjacent cycles.
- R3: The phase magnitude is unsigned. Its MSB weighs 1, and it is added at accumulator bit 7 after its 2 LSBs are dropped, so the addend is `phase_mag>>2`. Lock is reported when the lock preload plus the window's addends reaches 2^18, which is a carry out of bit 17, the 2^11 weight.
- R4: `trk_mode` at the first sample of a window selects the integration and lock preloads for that window: 0 uses the acquisition pair and 1 uses the tracking pair.
- R5: `lock_o` and `false_lock_o` change only in the cycle in which `done_o` is high. They hold their value until the next window ends.
- R6: Only samples taken with `verify`=1 feed the false-lock accumulator, which starts each window at `fl_pre`. With `fl_sel`=0 the addend is `freq_mag>>2`, and with `fl_sel`=1 it is `fl_bit` at bit 7, which is 128. False lock is reported when `fl_en`=1 and the sum reaches 2^18 by the last sample.
- R7: With `fl_en`=0 an overflow of the false-lock accumulator is ignored, and `false_lock_o` is 0 at the end of the window.
- R8: A `step` pulse with `trk_mode`=0 suppresses the next `dwell_pre`+1 windows. These windows still count samples but give no `done_o` pulse and no change to the flags. A `step` pulse with `trk_mode`=1, or entering track mode, cancels any hold-off.
- R9: A `step` pulse discards the partial window, and the next valid sample starts a fresh window. A sample that arrives in the same cycle as `step` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Error sample strobe |
| phase_mag | input | 10 | Phase error magnitude, 1 integer bit and 9 fraction bits |
| freq_mag | input | 10 | Frequency error magnitude, same format |
| fl_bit | input | 1 | False-lock indicator bit |
| trk_mode | input | 1 | 0 acquisition, 1 tracking |
| verify | input | 1 | Verify phase; enables the false-lock accumulator |
| fl_sel | input | 1 | False-lock source: 0 frequency magnitude, 1 indicator bit |
| fl_en | input | 1 | False-lock detection enable |
| step | input | 1 | Acquisition step pulse; restarts the window |
| integ_pre_acq | input | 10 | Window samples minus 2, acquisition |
| integ_pre_trk | input | 10 | Window samples minus 2, tracking |
| lock_pre_acq | input | 18 | Lock accumulator preload, acquisition |
| lock_pre_trk | input | 18 | Lock accumulator preload, tracking |
| fl_pre | input | 18 | False-lock accumulator preload |
| dwell_pre | input | 7 | Hold-off windows minus 1 |
| lock_o | output | 1 | Lock seen in the last reported window |
| false_lock_o | output | 1 | False lock seen in the last reported window |
| done_o | output | 1 | One-cycle window-end pulse |

## Verification
Random windows mix both modes, random window lengths and preloads that sit either side of the window's summed magnitude, so that lock and no-lock both occur often. Directed windows with a fixed magnitude put the sum exactly at 2^18 and one below it, which separates a correct carry test from an off-by-one compare or a wrong truncation. Windows with the two preload pairs set far apart show which pair, and which window length, the mode picked. Step pulses in each mode, in the middle of a window and together with a sample, separate a correct restart and dwell hold-off from one that counts the wrong windows or keeps a stale sample.

// File: rtl/lock_detector.sv
module lock_detector #(
  parameter int ACC_W   = 18,
  parameter int FRAC_W  = 7,
  parameter int MAG_W   = 10,
  parameter int CNT_W   = 10,
  parameter int DWELL_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_vld,
  input  logic [MAG_W-1:0]   phase_mag,
  input  logic [MAG_W-1:0]   freq_mag,
  input  logic               fl_bit,
  input  logic               trk_mode,
  input  logic               verify,
  input  logic               fl_sel,
  input  logic               fl_en,
  input  logic               step,
  input  logic [CNT_W-1:0]   integ_pre_acq,
  input  logic [CNT_W-1:0]   integ_pre_trk,
  input  logic [ACC_W-1:0]   lock_pre_acq,
  input  logic [ACC_W-1:0]   lock_pre_trk,
  input  logic [ACC_W-1:0]   fl_pre,
  input  logic [DWELL_W-1:0] dwell_pre,
  output logic               lock_o,
  output logic               false_lock_o,
  output logic               done_o
);
  localparam int TRUNC = MAG_W - 1 - FRAC_W;
  localparam int CW    = CNT_W + 1;
  localparam int HW    = DWELL_W + 1;

  logic             armed;
  logic [ACC_W-1:0] lk_acc, fl_acc;
  logic             lk_roll, fl_roll;
  logic [CW-1:0]    cnt;
  logic [HW-1:0]    hold;

  logic [ACC_W-1:0] ph_add, fq_add, fb_add, fl_add;
  logic [ACC_W-1:0] lk_base, fl_base, lk_sum, fl_sum;
  logic             lk_c, fl_c, lk_hit, fl_hit, last, held;
  logic [CW-1:0]    cnt_base;

  assign ph_add = ACC_W'(phase_mag[MAG_W-1:TRUNC]);
  assign fq_add = ACC_W'(freq_mag[MAG_W-1:TRUNC]);
  assign fb_add = ACC_W'(fl_bit) << FRAC_W;
  assign fl_add = !verify ? '0 : (fl_sel ? fb_add : fq_add);

  assign lk_base  = armed ? lk_acc : (trk_mode ? lock_pre_trk : lock_pre_acq);
  assign fl_base  = armed ? fl_acc : fl_pre;
  assign cnt_base = armed ? cnt
                          : CW'(trk_mode ? integ_pre_trk : integ_pre_acq) + CW'(1);

  assign {lk_c, lk_sum} = {1'b0, lk_base} + {1'b0, ph_add};
  assign {fl_c, fl_sum} = {1'b0, fl_base} + {1'b0, fl_add};

  assign lk_hit = lk_c | (armed & lk_roll);
  assign fl_hit = fl_c | (armed & fl_roll);
  assign last   = (cnt_base == '0);
  assign held   = (hold != '0) && !trk_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      lk_acc       <= '0;
      fl_acc       <= '0;
      lk_roll      <= 1'b0;
      fl_roll      <= 1'b0;
      cnt          <= '0;
      hold         <= '0;
      lock_o       <= 1'b0;
      false_lock_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (step) begin
        armed <= 1'b0;
        hold  <= HW'(dwell_pre) + HW'(1);
      end else if (smp_vld) begin
        if (last) begin
          armed <= 1'b0;
          if (held) begin
            hold <= hold - HW'(1);
          end else begin
            done_o       <= 1'b1;
            lock_o       <= lk_hit;
            false_lock_o <= fl_en & fl_hit;
          end
        end else begin
          armed   <= 1'b1;
          lk_acc  <= lk_sum;
          fl_acc  <= fl_sum;
          lk_roll <= lk_hit;
          fl_roll <= fl_hit;
          cnt     <= cnt_base - CW'(1);
        end
      end
      if (trk_mode) hold <= '0;
    end
  end
endmodule

// File: rtl/lock_detector_chk.sv
module lock_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic step,
  input logic trk_mode,
  input logic fl_en,
  input logic lock_o,
  input logic false_lock_o,
  input logic done_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!lock_o && !false_lock_o && !done_o));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r2_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(smp_vld && !step));

  a_r5_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(lock_o) && $stable(false_lock_o)));

  a_r7_fl_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(fl_en)) |-> !false_lock_o);

  a_r8_step_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !trk_mode) |=> !done_o);
endmodule

bind lock_detector lock_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .step(step),
  .trk_mode(trk_mode), .fl_en(fl_en), .lock_o(lock_o),
  .false_lock_o(false_lock_o), .done_o(done_o)
);

// File: tb/lock_detector_bench.sv
module lock_detector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0, fl_bit = 1'b0, trk_mode = 1'b0, verify = 1'b0;
  logic fl_sel = 1'b0, fl_en = 1'b0, step = 1'b0;
  logic [9:0]  phase_mag = '0, freq_mag = '0;
  logic [9:0]  integ_pre_acq = '0, integ_pre_trk = '0;
  logic [17:0] lock_pre_acq = '0, lock_pre_trk = '0, fl_pre = '0;
  logic [6:0]  dwell_pre = '0;
  logic lock_o, false_lock_o, done_o;

  int nchk = 0, nfail = 0;
  localparam longint FULL = 64'd262144;

  always #2 clk = ~clk;

  lock_detector u_lock_detector (.*);

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] ph, input logic [9:0] fq, input logic fb);
    int gap = $urandom_range(2, 0);
    repeat (gap) @(negedge clk);
    smp_vld = 1'b1; phase_mag = ph; freq_mag = fq; fl_bit = fb;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic pulse_step(input bit with_sample);
    @(negedge clk);
    step = 1'b1;
    if (with_sample) begin smp_vld = 1'b1; phase_mag = 10'h3FF; end
    @(negedge clk);
    step = 1'b0; smp_vld = 1'b0;
  endtask

  function automatic longint win_len();
    return longint'(trk_mode ? integ_pre_trk : integ_pre_acq) + 2;
  endfunction

  // fm < 0: random magnitudes
  task automatic run_win(input bit held, input int fm, input string tag);
    longint n  = win_len();
    longint ls = longint'(trk_mode ? lock_pre_trk : lock_pre_acq);
    longint fs = longint'(fl_pre);
    bit bad_done = 0, bad_hold = 0;
    logic l0 = lock_o, f0 = false_lock_o;
    for (longint i = 0; i < n; i++) begin
      logic [9:0] ph = (fm >= 0) ? 10'(fm) : 10'($urandom);
      logic [9:0] fq = 10'($urandom);
      logic       fb = 1'($urandom);
      ls += longint'(ph >> 2);
      if (verify) fs += fl_sel ? (fb ? 128 : 0) : longint'(fq >> 2);
      send(ph, fq, fb);
      if (i < n - 1 || held) begin
        if (done_o) bad_done = 1;
        if (lock_o !== l0 || false_lock_o !== f0) bad_hold = 1;
      end
    end
    check(!bad_done, {tag, " R2 no done inside window"}, bad_done, 0);
    check(!bad_hold, {tag, " R5 flags held"}, bad_hold, 0);
    if (!held) begin
      check(done_o === 1'b1, {tag, " R2 done at window end"}, done_o, 1);
      check(lock_o === (ls >= FULL), {tag, " R3 lock"}, lock_o, ls >= FULL);
      check(false_lock_o === (fl_en && fs >= FULL),
            {tag, fl_en ? " R6 false lock" : " R7 false lock ignored"},
            false_lock_o, fl_en && fs >= FULL);
      @(negedge clk);
      check(done_o === 1'b0, {tag, " R2 single pulse"}, done_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!lock_o && !false_lock_o && !done_o, "R1 reset outputs", {lock_o, false_lock_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!lock_o && !false_lock_o && !done_o, "R1 after reset", {lock_o, false_lock_o, done_o}, 0);

    // R3 boundary: two samples of 255 each
    integ_pre_acq = 10'd0;
    lock_pre_acq = 18'(FULL - 510);
    run_win(0, 1020, "R3 exact");
    lock_pre_acq = 18'(FULL - 511);
    run_win(0, 1023, "R3 one short");

    // R4 preload pair selection
    integ_pre_acq = 10'd1; integ_pre_trk = 10'd3;
    lock_pre_acq = 18'(FULL - 200); lock_pre_trk = 18'd0;
    trk_mode = 1'b1; run_win(0, 1020, "R4 track pair");
    trk_mode = 1'b0; lock_pre_acq = 18'(FULL - 765); run_win(0, 1020, "R4 acq pair");

    // random windows
    for (int k = 0; k < 40; k++) begin
      longint n;
      trk_mode = 1'($urandom); verify = 1'($urandom);
      fl_sel = 1'($urandom); fl_en = 1'($urandom);
      integ_pre_acq = 10'($urandom_range(12, 0));
      integ_pre_trk = 10'($urandom_range(12, 0));
      n = win_len();
      lock_pre_acq = 18'(FULL - $urandom_range(32'(n * 255), 1));
      lock_pre_trk = 18'(FULL - $urandom_range(32'(n * 255), 1));
      fl_pre       = 18'(FULL - $urandom_range(32'(n * 200), 1));
      run_win(0, -1, "rand");
    end

    // longest window
    trk_mode = 1'b0; verify = 1'b1; fl_sel = 1'b1; fl_en = 1'b1;
    integ_pre_acq = 10'd1023;
    lock_pre_acq = 18'(FULL - 130000); fl_pre = 18'(FULL - 60000);
    run_win(0, -1, "R2 1025 samples");

    // R8 dwell hold-off in acquisition
    integ_pre_acq = 10'd2; dwell_pre = 7'd2; fl_en = 1'b0;
    lock_pre_acq = 18'(FULL - 10);
    pulse_step(0);
    for (int h = 0; h < 3; h++) run_win(1, -1, "R8 held window");
    run_win(0, 1020, "R8 first window after dwell");
    // R8 step in track mode: no hold-off
    trk_mode = 1'b1; integ_pre_trk = 10'd2; lock_pre_trk = 18'd5;
    pulse_step(0);
    run_win(0, -1, "R8 track step no hold");

    // R9 step mid window, then step together with a sample
    integ_pre_trk = 10'd5;
    for (int j = 0; j < 3; j++) send(10'h3FF, 10'h0, 1'b0);
    check(done_o === 1'b0, "R9 partial window no done", done_o, 0);
    pulse_step(0);
    lock_pre_trk = 18'(FULL - 2000);
    run_win(0, 400, "R9 restart after step");
    pulse_step(1);
    run_win(0, 400, "R9 sample with step dropped");

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule